// File: doc/BRIEF.md
# Strided Banked Vector Memory Controller

This block moves one vector between a vector register port and a word-interleaved memory made of several banks. A command gives a base word address, a stride and an element count, and says whether the vector is loaded or stored. The controller walks the element addresses one by one. It picks the bank from the low address bits and sends at most one element request per cycle. When the bank it needs is still recovering from an earlier access, it waits.

Each bank has a recovery timer that starts when the bank accepts an access. Strides that keep hitting the same bank therefore slow issue down to the recovery rate. Load data come back after a fixed latency, tagged with the element index and in element order. A one-cycle completion pulse closes every command. The bank storage is a plain array inside the block, so the whole path can be exercised at the ports.

Top module: `vmem_stride_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `cmd_ready` is 1 and `done`, `stall`, `st_req` and `ld_valid` are 0.
- R2: Element i uses word address (base + i*stride) mod 256. Its bank is address bits [3:0] and its row within the bank is bits [7:4]. A load of an address returns the word most recently stored there.
- R3: At most one element request reaches the banks in any cycle, and elements are requested in increasing index order.
- R4: Once a bank takes an access in cycle t, it takes no other access before cycle t+4. While the next element waits for such a bank, `stall` is 1 and no request is issued. A stride of 0 or a multiple of 16 therefore issues one element every 4 cycles.
- R5: Load data for an element appear on `ld_data` with `ld_valid` exactly 12 cycles after the element's request cycle. `ld_idx` counts 0,1,2,... within the command, even when stalls move the request times.
- R6: A store element is requested with `st_req` = 1 and its index on `st_idx`. `st_data` is sampled in that same cycle and written to the element's address.
- R7: `cmd_len` is sampled when the command is accepted. Values above 64 are treated as 64. A length of 0 makes no bank access.
- R8: `done` is a one-cycle pulse. For a store it comes one cycle after the last element's request cycle. For a load it comes one cycle after the last `ld_valid`. For length 0 it comes the cycle after acceptance. `cmd_ready` is 1 exactly when no command is in progress, and a command is accepted on a clock edge with `cmd_valid` and `cmd_ready` both 1.
- R9: Bank recovery carries over from one command to the next. A command that starts right after `done` stalls on a bank that the previous command touched less than 4 cycles before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_store | input | 1 | 1 = store vector, 0 = load vector |
| cmd_base | input | 8 | Base word address |
| cmd_stride | input | 8 | Stride in words, modulo 256 |
| cmd_len | input | 7 | Element count, clamped to 64 |
| st_req | output | 1 | Store element request, `st_data` read this cycle |
| st_idx | output | 6 | Index of the store element requested |
| st_data | input | 64 | Store element data from the vector register |
| ld_valid | output | 1 | Load element data valid |
| ld_idx | output | 6 | Index of the returned load element |
| ld_data | output | 64 | Returned load element data |
| stall | output | 1 | Next element is waiting for a busy bank |
| done | output | 1 | Command completion pulse |

## Verification
During a load, write-back of element k and the request, or the stall, of a later element fall in the same cycle. A stall must never disturb the order or timing of data already in flight. Strides of 8, 24 and 0 force bank repeats, which makes stalls overlap the return stream. The bench judges each returned word by its index and by a memory image it builds from earlier stores, and compares the count of stall cycles and the cycle of `done` against values worked out from the recovery and latency rules. A store followed at once by a load to the same bank shows recovery crossing a command boundary while `done` and the new command's first stall fall in adjacent cycles.

// File: rtl/vmem_pkg.sv
package vmem_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_DRAIN = 2'd2
    } phase_e;

endpackage

// File: rtl/vmem_bank_timers.sv
module vmem_bank_timers #(
    parameter int NBANK = 16,
    parameter int BUSY  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBANK-1:0] take,
    output logic [NBANK-1:0] busy
);

    localparam int CW = (BUSY > 2) ? $clog2(BUSY) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(BUSY - 1);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (take[b]) begin
                cnt_d = RELOAD;
            end else if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign busy[b] = (cnt_q != '0);
    end

endmodule

// File: rtl/vmem_bank_array.sv
module vmem_bank_array #(
    parameter  int NBANK  = 16,
    parameter  int ROW_W  = 4,
    parameter  int DW     = 64,
    localparam int BANK_W = $clog2(NBANK),
    localparam int ROWS   = 1 << ROW_W
) (
    input  logic              clk,
    input  logic [NBANK-1:0]  sel,
    input  logic              we,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [ROW_W-1:0]  row,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);

    logic [DW-1:0] rd_word [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DW-1:0] mem [ROWS];

        always_ff @(posedge clk) begin
            if (sel[b] && we) begin
                mem[row] <= wdata;
            end
        end

        assign rd_word[b] = mem[row];
    end

    assign rdata = rd_word[rd_bank];

endmodule

// File: rtl/vmem_ret_pipe.sv
module vmem_ret_pipe #(
    parameter int DEPTH = 12,
    parameter int IDX_W = 6,
    parameter int DW    = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [DW-1:0]    in_data,
    output logic             out_valid,
    output logic             out_last,
    output logic [IDX_W-1:0] out_idx,
    output logic [DW-1:0]    out_data
);

    typedef struct packed {
        logic             vld;
        logic             last;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    data;
    } slot_t;

    slot_t pipe_d [DEPTH];
    slot_t pipe_q [DEPTH];

    always_comb begin
        pipe_d[0] = {in_valid, in_last, in_idx, in_data};
        for (int k = 1; k < DEPTH; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                pipe_q[k] <= '0;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q[DEPTH-1].vld;
    assign out_last  = pipe_q[DEPTH-1].last;
    assign out_idx   = pipe_q[DEPTH-1].idx;
    assign out_data  = pipe_q[DEPTH-1].data;

endmodule

// File: rtl/vmem_stride_ctrl.sv
module vmem_stride_ctrl #(
    parameter  int DW     = 64,
    parameter  int ADDR_W = 8,
    parameter  int NBANK  = 16,
    parameter  int BUSY   = 4,
    parameter  int LAT    = 12,
    parameter  int MAXLEN = 64,
    localparam int BANK_W = $clog2(NBANK),
    localparam int ROW_W  = ADDR_W - BANK_W,
    localparam int LEN_W  = $clog2(MAXLEN + 1),
    localparam int IDX_W  = $clog2(MAXLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_store,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [ADDR_W-1:0] cmd_stride,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              st_req,
    output logic [IDX_W-1:0]  st_idx,
    input  logic [DW-1:0]     st_data,
    output logic              ld_valid,
    output logic [IDX_W-1:0]  ld_idx,
    output logic [DW-1:0]     ld_data,
    output logic              stall,
    output logic              done
);

    import vmem_pkg::*;

    typedef struct packed {
        phase_e            phase;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] stride;
        logic              store;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    logic [NBANK-1:0]  bank_busy;
    logic [NBANK-1:0]  bank_req;
    logic [BANK_W-1:0] cur_bank;
    logic [ROW_W-1:0]  cur_row;
    logic              can_issue;
    logic [DW-1:0]     rd_word;
    logic [LEN_W-1:0]  eff_len;
    logic              ret_valid;
    logic              ret_last;
    logic [IDX_W-1:0]  ret_idx;
    logic [DW-1:0]     ret_data;

    // current element's bank (low bits) and row (high bits)
    assign cur_bank = s_q.addr[BANK_W-1:0];
    assign cur_row  = s_q.addr[ADDR_W-1:BANK_W];

    assign can_issue = (s_q.phase == PH_ISSUE) && !bank_busy[cur_bank];
    assign bank_req  = can_issue ? (NBANK'(1) << cur_bank) : '0;

    assign eff_len = (cmd_len > LEN_W'(MAXLEN)) ? LEN_W'(MAXLEN) : cmd_len;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (cmd_valid) begin
                    if (eff_len == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.phase  = PH_ISSUE;
                        s_d.idx    = '0;
                        s_d.last   = IDX_W'(eff_len - 1'b1);
                        s_d.addr   = cmd_base;
                        s_d.stride = cmd_stride;
                        s_d.store  = cmd_store;
                    end
                end
            end
            PH_ISSUE: begin
                if (can_issue) begin
                    if (s_q.idx == s_q.last) begin
                        if (s_q.store) begin
                            s_d.phase = PH_IDLE;
                            s_d.done  = 1'b1;
                        end else begin
                            s_d.phase = PH_DRAIN;
                        end
                    end else begin
                        s_d.idx  = s_q.idx + 1'b1;
                        s_d.addr = s_q.addr + s_q.stride;
                    end
                end
            end
            PH_DRAIN: begin
                if (ret_valid && ret_last) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    vmem_bank_timers #(
        .NBANK (NBANK),
        .BUSY  (BUSY)
    ) u_timers (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (bank_req),
        .busy  (bank_busy)
    );

    vmem_bank_array #(
        .NBANK (NBANK),
        .ROW_W (ROW_W),
        .DW    (DW)
    ) u_banks (
        .clk     (clk),
        .sel     (bank_req),
        .we      (s_q.store),
        .rd_bank (cur_bank),
        .row     (cur_row),
        .wdata   (st_data),
        .rdata   (rd_word)
    );

    vmem_ret_pipe #(
        .DEPTH (LAT),
        .IDX_W (IDX_W),
        .DW    (DW)
    ) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (can_issue && !s_q.store),
        .in_last   (s_q.idx == s_q.last),
        .in_idx    (s_q.idx),
        .in_data   (rd_word),
        .out_valid (ret_valid),
        .out_last  (ret_last),
        .out_idx   (ret_idx),
        .out_data  (ret_data)
    );

    assign cmd_ready = (s_q.phase == PH_IDLE);
    assign stall     = (s_q.phase == PH_ISSUE) && bank_busy[cur_bank];
    assign st_req    = can_issue && s_q.store;
    assign st_idx    = s_q.idx;
    assign ld_valid  = ret_valid;
    assign ld_idx    = ret_idx;
    assign ld_data   = ret_data;
    assign done      = s_q.done;

endmodule

// File: rtl/vmem_stride_ctrl_chk.sv
module vmem_stride_ctrl_chk #(
    parameter int NBANK = 16,
    parameter int BUSY  = 4,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             stall,
    input logic             done,
    input logic             st_req,
    input logic [IDX_W-1:0] st_idx,
    input logic             ld_valid,
    input logic [IDX_W-1:0] ld_idx,
    input logic [NBANK-1:0] bank_req
);

    localparam int SW = $clog2(BUSY + 1) + 1;

    logic [IDX_W:0] ld_exp_q, st_exp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_exp_q <= '0;
            st_exp_q <= '0;
        end else if (cmd_valid && cmd_ready) begin
            ld_exp_q <= '0;
            st_exp_q <= '0;
        end else begin
            if (ld_valid) ld_exp_q <= ld_exp_q + 1'b1;
            if (st_req)   st_exp_q <= st_exp_q + 1'b1;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_gap
        logic [SW-1:0] since_q;
        logic          seen_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                since_q <= '0;
                seen_q  <= 1'b0;
            end else if (bank_req[b]) begin
                since_q <= SW'(1);
                seen_q  <= 1'b1;
            end else if (since_q < SW'(BUSY)) begin
                since_q <= since_q + 1'b1;
            end
        end

        // R4: spacing between two accesses to one bank
        assert_bank_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_req[b] && seen_q) |-> (since_q >= SW'(BUSY)));
    end

    assert_one_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_req));

    assert_stall_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (bank_req == '0));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    assert_ld_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> (ld_idx == ld_exp_q[IDX_W-1:0]));

    assert_st_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> (st_idx == st_exp_q[IDX_W-1:0]));

endmodule

bind vmem_stride_ctrl vmem_stride_ctrl_chk #(
    .NBANK (NBANK),
    .BUSY  (BUSY),
    .IDX_W (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .stall     (stall),
    .done      (done),
    .st_req    (st_req),
    .st_idx    (st_idx),
    .ld_valid  (ld_valid),
    .ld_idx    (ld_idx),
    .bank_req  (bank_req)
);

// File: tb/vmem_stride_ctrl_test.sv
module vmem_stride_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    // {store, base, stride, len, done latency, stall cycles}
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b1, 8'd0,   8'd1,   8'd64,  8'd65, 8'd0},
        {1'b1, 8'd64,  8'd1,   8'd64,  8'd65, 8'd0},
        {1'b1, 8'd128, 8'd1,   8'd64,  8'd65, 8'd0},
        {1'b1, 8'd192, 8'd1,   8'd64,  8'd65, 8'd0},
        {1'b0, 8'd0,   8'd1,   8'd16,  8'd29, 8'd0},
        {1'b0, 8'd5,   8'd16,  8'd4,   8'd26, 8'd9},
        {1'b1, 8'd3,   8'd8,   8'd6,   8'd11, 8'd4},
        {1'b0, 8'd3,   8'd8,   8'd6,   8'd23, 8'd4},
        {1'b0, 8'd200, 8'd0,   8'd3,   8'd22, 8'd6},
        {1'b1, 8'd250, 8'd3,   8'd20,  8'd21, 8'd0},
        {1'b0, 8'd250, 8'd3,   8'd20,  8'd33, 8'd0},
        {1'b1, 8'd7,   8'd255, 8'd8,   8'd9,  8'd0},
        {1'b0, 8'd0,   8'd1,   8'd64,  8'd77, 8'd0},
        {1'b1, 8'd0,   8'd0,   8'd5,   8'd18, 8'd12},
        {1'b0, 8'd0,   8'd16,  8'd4,   8'd26, 8'd9},
        {1'b1, 8'd100, 8'd1,   8'd100, 8'd65, 8'd0},
        {1'b0, 8'd100, 8'd1,   8'd64,  8'd77, 8'd0},
        {1'b0, 8'd9,   8'd24,  8'd8,   8'd27, 8'd6}
    };

    logic        clk;
    logic        rst_n;
    logic        cmd_valid;
    logic        cmd_ready;
    logic        cmd_store;
    logic [7:0]  cmd_base;
    logic [7:0]  cmd_stride;
    logic [6:0]  cmd_len;
    logic        st_req;
    logic [5:0]  st_idx;
    logic [63:0] st_data;
    logic        ld_valid;
    logic [5:0]  ld_idx;
    logic [63:0] ld_data;
    logic        stall;
    logic        done;

    logic [31:0] cur_tag;
    logic [63:0] image [256];
    int n_chk;
    int n_bad;

    vmem_stride_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_store  (cmd_store),
        .cmd_base   (cmd_base),
        .cmd_stride (cmd_stride),
        .cmd_len    (cmd_len),
        .st_req     (st_req),
        .st_idx     (st_idx),
        .st_data    (st_data),
        .ld_valid   (ld_valid),
        .ld_idx     (ld_idx),
        .ld_data    (ld_data),
        .stall      (stall),
        .done       (done)
    );

    // vector register side: store data tagged by command and element index
    assign st_data = {cur_tag, 26'd0, st_idx};

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int eaddr(input int b, input int s, input int i);
        return (b + i * s) & 255;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge where done is seen
    task automatic run_cmd(input string tag, input bit store, input int base,
                           input int stride, input int len, input int exp_lat,
                           input int exp_stall, input int exp_first);
        int lat = 0;
        int n_stall = 0;
        int st_cnt = 0;
        int ld_cnt = 0;
        int first_ret = 0;
        int eff = (len > 64) ? 64 : len;
        check(cmd_ready == 1'b1, {tag, " R8 ready before command"}, 64'(cmd_ready), 64'd1);
        cmd_store  = store;
        cmd_base   = 8'(base);
        cmd_stride = 8'(stride);
        cmd_len    = 7'(len);
        cmd_valid  = 1'b1;
        while (1) begin
            @(negedge clk);
            lat++;
            if (lat == 1) cmd_valid = 1'b0;
            if (stall) n_stall++;
            if (st_req) begin
                check(int'(st_idx) == st_cnt, {tag, " R6 store index order"},
                      64'(st_idx), 64'(st_cnt));
                image[eaddr(base, stride, int'(st_idx))] = st_data;
                st_cnt++;
            end
            if (ld_valid) begin
                if (ld_cnt == 0) first_ret = lat;
                check(int'(ld_idx) == ld_cnt, {tag, " R5 load index order"},
                      64'(ld_idx), 64'(ld_cnt));
                check(ld_data == image[eaddr(base, stride, int'(ld_idx))],
                      {tag, " R2 load data"}, ld_data,
                      image[eaddr(base, stride, int'(ld_idx))]);
                ld_cnt++;
            end
            if (done) break;
            if (lat > 2000) begin
                check(1'b0, {tag, " R8 done never seen"}, 64'(lat), 64'(exp_lat));
                break;
            end
        end
        check(lat == exp_lat, {tag, " R8 done latency"}, 64'(lat), 64'(exp_lat));
        check(n_stall == exp_stall, {tag, " R4 stall cycles"}, 64'(n_stall), 64'(exp_stall));
        if (store) begin
            check(st_cnt == eff, {tag, " R7 store element count"}, 64'(st_cnt), 64'(eff));
            check(ld_cnt == 0, {tag, " R3 no load return on store"}, 64'(ld_cnt), 64'd0);
        end else begin
            check(ld_cnt == eff, {tag, " R7 load element count"}, 64'(ld_cnt), 64'(eff));
            check(st_cnt == 0, {tag, " R3 no store request on load"}, 64'(st_cnt), 64'd0);
        end
        if (exp_first != 0) begin
            check(first_ret == exp_first, {tag, " R5 first return cycle"},
                  64'(first_ret), 64'(exp_first));
        end
    endtask

    task automatic idle_gap(input string tag);
        @(negedge clk);
        check(done == 1'b0, {tag, " R8 done is one cycle"}, 64'(done), 64'd0);
        check(cmd_ready == 1'b1, {tag, " R8 ready when idle"}, 64'(cmd_ready), 64'd1);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        n_chk      = 0;
        n_bad      = 0;
        cur_tag    = 32'd0;
        rst_n      = 1'b0;
        cmd_valid  = 1'b0;
        cmd_store  = 1'b0;
        cmd_base   = '0;
        cmd_stride = '0;
        cmd_len    = '0;
        for (int a = 0; a < 256; a++) image[a] = '0;

        // R1: quiet outputs in and just after reset
        repeat (3) @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            check(cmd_ready == 1'b1, "R1 cmd_ready", 64'(cmd_ready), 64'd1);
            check(done == 1'b0, "R1 done", 64'(done), 64'd0);
            check(stall == 1'b0, "R1 stall", 64'(stall), 64'd0);
            check(st_req == 1'b0, "R1 st_req", 64'(st_req), 64'd0);
            check(ld_valid == 1'b0, "R1 ld_valid", 64'(ld_valid), 64'd0);
            rst_n = 1'b1;
            @(negedge clk);
        end

        // vector table: fill, strided reads/writes, bank conflicts, clamp
        for (int v = 0; v < NVEC; v++) begin
            cur_tag = 32'hA500_0000 + 32'(v);
            run_cmd($sformatf("vec%0d", v), VEC[v][40], int'(VEC[v][39:32]),
                    int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]),
                    int'(VEC[v][7:0]), VEC[v][40] ? 0 : 13);
            idle_gap($sformatf("vec%0d", v));
        end

        // R7: zero length store and load make no access
        cur_tag = 32'hBEEF_0001;
        run_cmd("len0 store R7", 1'b1, 16, 1, 0, 1, 0, 0);
        idle_gap("len0 store");
        run_cmd("len0 load R7", 1'b0, 16, 1, 0, 1, 0, 0);
        idle_gap("len0 load");
        // R7: zero length store left the words untouched
        run_cmd("len0 readback R7", 1'b0, 16, 1, 4, 17, 0, 13);
        idle_gap("len0 readback");

        // R9: store to bank 0 then an immediate load from bank 0
        cur_tag = 32'hBEEF_0002;
        run_cmd("back2back store R9", 1'b1, 32, 16, 1, 2, 0, 0);
        run_cmd("back2back load R9", 1'b0, 32, 16, 1, 16, 2, 15);
        idle_gap("back2back");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule